// File: doc/BRIEF.md
# USB Host Controller Register File

This block holds the software-visible registers of a two-port full/low-speed USB host controller. A simple byte-addressed slave port writes 16-bit halfwords and reads them back combinationally. Behind it sit a command word, a sticky status word, an interrupt mask, the frame counter, the 4 KiB-aligned frame list pointer, the start-of-frame timing byte and one status/control word per root port.

Hardware events from the schedule engine and from the port logic are latched into sticky bits, and software clears them by writing ones. A single interrupt line is raised from the status bits whose enables are set. The run, max-packet and reset controls, the frame list pointer, the frame number and the SOF byte are driven straight out to the scheduler. A software reset of the controller returns the whole register set to its power-up contents in one cycle.

Top module: `usbhc_regs`

## Requirements
- R1: Registers sit at halfword byte offsets: 0x00 command, 0x02 status, 0x04 interrupt enable, 0x06 frame number, 0x08/0x0A frame list pointer low/high half, 0x0C SOF byte, 0x10 port 0, 0x12 port 1. Address bit 0 is ignored, and every other offset reads 0x0000.
- R2: Command bit 0 (run) drives `run_o` and bit 7 (64-byte max packet) drives `max64_o`. Both read back, and every other command bit reads zero.
- R3: Status bit 5 reads 1 exactly when the run bit is 0.
- R4: Status bits 4:0 (0 timeout/CRC, 1 resume, 2 complete, 3 short packet, 4 process error) are set by `ev_i` at the same bit position one cycle after the pulse. Writing 1 to a bit clears it, and writing 0 leaves it alone. An event in the same cycle as a clear of the same bit leaves the bit set.
- R5: Interrupt enable bits 3:0 are read/write, and bits 15:4 read zero. `irq_o` is high whenever any of status bits 3:0 is set together with its enable bit. Process error never raises `irq_o`.
- R6: The frame number is 11 bits wide and bits 15:11 read zero. It can be written, and it advances by one per `frame_tick` cycle, wrapping from 0x7FF to 0. A write in the same cycle as a tick wins.
- R7: The frame list pointer keeps only bits 31:12. Bits 11:0 read zero and ignore writes, and `flbase_o` shows the stored pointer.
- R8: The SOF byte resets to 0x40, is written from the low data byte, reads in bits 7:0 with the upper byte zero, and drives `sof_o`.
- R9: Port bit 0 shows `port_conn` one cycle late. Port bit 1 is set when the connect input differs from the shown value and is cleared by writing 1, with the event winning over the clear.
- R10: Port bit 2 shows `port_en` one cycle late. Port bit 3 is set when it changes and is cleared by writing 1.
- R11: Port bit 8 shows `port_ls`, and bit 7 always reads 1. Bit 9 is read/write and drives `port_rst_o`. Bits 15:10, 6 and 5:4 read zero.
- R12: Writing command bit 1 as 1 returns every register to its reset value at that clock edge, and that write's other bits are discarded. Bit 1 always reads 0, and `hc_rst_o` pulses high for the following cycle.
- R13: After `rst_n` the reads are: command 0x0000, status 0x0020, enables 0x0000, frame 0x0000, pointer 0x0000/0x0000, SOF 0x0040, ports 0x0080. `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the halfword at `bus_addr` |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| ev_i | input | 5 | Event pulses, one per status bit 4:0 |
| frame_tick | input | 1 | Advance the frame number |
| port_conn | input | 2 | Device present, one bit per port |
| port_en | input | 2 | Port enabled, one bit per port |
| port_ls | input | 2 | Low-speed device, one bit per port |
| run_o | output | 1 | Execute the schedule |
| max64_o | output | 1 | Max packet is 64 bytes |
| hc_rst_o | output | 1 | One-cycle controller reset pulse |
| port_rst_o | output | 2 | Hold port in bus reset |
| flbase_o | output | 32 | Frame list pointer |
| frnum_o | output | 11 | Current frame number |
| sof_o | output | 8 | SOF timing byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The sticky status logic is tried with random event vectors against random clear masks. Many of those cycles carry an event and a clear on the same bit, which separates event-wins from clear-wins behaviour, while the random enable mask shows whether `irq_o` follows only the enabled bits. Random connect and enable toggles on both ports, mixed with random write-one clears, show whether a change bit is lost, set twice or cleared by a zero. Directed cases cover the frame counter wrap, writes to the masked low pointer bits, reserved bits and the software reset taking precedence over the other bits in its own write.

// File: rtl/usbhc_regs_pkg.sv
// Package: shared halfword indices and constants of the host controller
// register file. Assumes 16-bit halfword decode on address bits [4:1].
package usbhc_regs_pkg;
    localparam int HW_CMD    = 0;
    localparam int HW_STS    = 1;
    localparam int HW_IEN    = 2;
    localparam int HW_FRNUM  = 3;
    localparam int HW_BASELO = 4;
    localparam int HW_BASEHI = 5;
    localparam int HW_SOF    = 6;
    localparam int HW_PORT0  = 8;
    localparam int NEVT      = 5;
    localparam int NIRQ      = 4;
endpackage

// File: rtl/usbhc_status.sv
// Module: usbhc_status
// Sticky status bits with write-one-to-clear, the interrupt enable mask and
// the interrupt output. Assumes ev pulses are synchronous to clk; an event
// wins over a clear of the same bit, and the soft clear wins over everything.
module usbhc_status
    import usbhc_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic [NEVT-1:0] ev,
    input  logic        sts_wr,
    input  logic        ien_wr,
    input  logic [15:0] wdata,
    input  logic        run,
    output logic [15:0] sts_rd,
    output logic [15:0] ien_rd,
    output logic        irq
);
    logic [NEVT-1:0] sts_q;
    logic [NIRQ-1:0] ien_q;
    logic [NEVT-1:0] clr_mask;

    // Clear mask from a status write.
    assign clr_mask = sts_wr ? wdata[NEVT-1:0] : '0;

    // Sticky status update: clear first, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sts_q <= '0;
        else               sts_q <= (sts_q & ~clr_mask) | ev;
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) ien_q <= '0;
        else if (ien_wr)   ien_q <= wdata[NIRQ-1:0];
    end

    // Read views and interrupt.
    always_comb begin
        sts_rd = '0;
        sts_rd[NEVT-1:0] = sts_q;
        sts_rd[5] = ~run;
        ien_rd = '0;
        ien_rd[NIRQ-1:0] = ien_q;
        irq = |(sts_q[NIRQ-1:0] & ien_q);
    end
endmodule

// File: rtl/usbhc_port.sv
// Module: usbhc_port
// One root port status/control word. Connect and enable inputs are sampled
// each cycle; a difference between input and sampled value sets the change
// flag, which software clears by writing one. Assumes inputs are synchronous.
module usbhc_port (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        conn_i,
    input  logic        en_i,
    input  logic        ls_i,
    input  logic        wr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        prst_o
);
    logic conn_q, en_q, cchg_q, echg_q, prst_q;

    // Samplers track the inputs; only the power-on reset touches them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conn_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            conn_q <= conn_i;
            en_q   <= en_i;
        end
    end

    // Change flags: set on a difference, cleared by a one write, event wins.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cchg_q <= 1'b0;
            echg_q <= 1'b0;
        end else begin
            cchg_q <= (conn_i ^ conn_q) | (cchg_q & ~(wr & wdata[1]));
            echg_q <= (en_i ^ en_q)     | (echg_q & ~(wr & wdata[3]));
        end
    end

    // Port bus-reset control bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) prst_q <= 1'b0;
        else if (wr)       prst_q <= wdata[9];
    end

    // Read view of the port word.
    assign rdata  = {6'b0, prst_q, ls_i, 1'b1, 1'b0, 2'b00,
                     echg_q, en_q, cchg_q, conn_q};
    assign prst_o = prst_q;
endmodule

// File: rtl/usbhc_regs.sv
// Module: usbhc_regs (top)
// Register file of a two-port USB 1.x host controller: halfword decode,
// command, frame number, frame list pointer and SOF byte, plus instances
// of the status block and one port block per root port. Reads are
// combinational from registered state; address bit 0 is ignored.
module usbhc_regs
    import usbhc_regs_pkg::*;
#(
    parameter int AW      = 5,
    parameter int DW      = 16,
    parameter int NPORT   = 2,
    parameter int FRM_W   = 11,
    parameter int SOF_RST = 8'h40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NEVT-1:0]  ev_i,
    input  logic             frame_tick,
    input  logic [NPORT-1:0] port_conn,
    input  logic [NPORT-1:0] port_en,
    input  logic [NPORT-1:0] port_ls,
    output logic             run_o,
    output logic             max64_o,
    output logic             hc_rst_o,
    output logic [NPORT-1:0] port_rst_o,
    output logic [31:0]      flbase_o,
    output logic [FRM_W-1:0] frnum_o,
    output logic [7:0]       sof_o,
    output logic             irq_o
);
    localparam int HWI_W = AW - 1;

    logic [HWI_W-1:0] hw_idx;
    logic             soft_clr;
    logic             run_q, max64_q, hcr_q;
    logic [FRM_W-1:0] frnum_q;
    logic [19:0]      base_q;
    logic [7:0]       sof_q;
    logic [15:0]      sts_rd, ien_rd;
    logic [15:0]      port_rd [NPORT];

    assign hw_idx   = bus_addr[AW-1:1];
    assign soft_clr = bus_wr && (hw_idx == HWI_W'(HW_CMD)) && bus_wdata[1];

    // Command bits; a soft reset write discards its other bits.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            run_q   <= 1'b0;
            max64_q <= 1'b0;
        end else if (bus_wr && hw_idx == HWI_W'(HW_CMD)) begin
            run_q   <= bus_wdata[0];
            max64_q <= bus_wdata[7];
        end
    end

    // One-cycle reset pulse to the scheduler.
    always_ff @(posedge clk) begin
        if (!rst_n) hcr_q <= 1'b0;
        else        hcr_q <= soft_clr;
    end

    // Frame counter: write wins over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) frnum_q <= '0;
        else if (bus_wr && hw_idx == HWI_W'(HW_FRNUM)) frnum_q <= bus_wdata[FRM_W-1:0];
        else if (frame_tick) frnum_q <= frnum_q + 1'b1;
    end

    // Frame list pointer, upper 20 bits only.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) base_q <= '0;
        else if (bus_wr && hw_idx == HWI_W'(HW_BASELO)) base_q[3:0]  <= bus_wdata[15:12];
        else if (bus_wr && hw_idx == HWI_W'(HW_BASEHI)) base_q[19:4] <= bus_wdata;
    end

    // SOF timing byte.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) sof_q <= 8'(SOF_RST);
        else if (bus_wr && hw_idx == HWI_W'(HW_SOF)) sof_q <= bus_wdata[7:0];
    end

    usbhc_status u_sts (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (soft_clr),
        .ev     (ev_i),
        .sts_wr (bus_wr && hw_idx == HWI_W'(HW_STS)),
        .ien_wr (bus_wr && hw_idx == HWI_W'(HW_IEN)),
        .wdata  (bus_wdata),
        .run    (run_q),
        .sts_rd (sts_rd),
        .ien_rd (ien_rd),
        .irq    (irq_o)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        usbhc_port u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (soft_clr),
            .conn_i (port_conn[p]),
            .en_i   (port_en[p]),
            .ls_i   (port_ls[p]),
            .wr     (bus_wr && hw_idx == HWI_W'(HW_PORT0 + p)),
            .wdata  (bus_wdata),
            .rdata  (port_rd[p]),
            .prst_o (port_rst_o[p])
        );
    end

    // Read multiplexer over the halfword index.
    always_comb begin
        bus_rdata = '0;
        case (hw_idx)
            HWI_W'(HW_CMD):    bus_rdata = {8'h00, max64_q, 6'b0, run_q};
            HWI_W'(HW_STS):    bus_rdata = sts_rd;
            HWI_W'(HW_IEN):    bus_rdata = ien_rd;
            HWI_W'(HW_FRNUM):  bus_rdata = 16'(frnum_q);
            HWI_W'(HW_BASELO): bus_rdata = {base_q[3:0], 12'h000};
            HWI_W'(HW_BASEHI): bus_rdata = base_q[19:4];
            HWI_W'(HW_SOF):    bus_rdata = {8'h00, sof_q};
            default:           bus_rdata = '0;
        endcase
        for (int p = 0; p < NPORT; p++)
            if (hw_idx == HWI_W'(HW_PORT0 + p)) bus_rdata = port_rd[p];
    end

    assign run_o    = run_q;
    assign max64_o  = max64_q;
    assign hc_rst_o = hcr_q;
    assign flbase_o = {base_q, 12'h000};
    assign frnum_o  = frnum_q;
    assign sof_o    = sof_q;
endmodule

// File: rtl/usbhc_regs_chk.sv
// Module: usbhc_regs_chk
// Property checker bound into usbhc_regs; observes ports and the internal
// status/enable views and soft reset strobe.
module usbhc_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [4:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic [15:0] bus_rdata,
    input logic [4:0]  ev_i,
    input logic        run_o,
    input logic [7:0]  sof_o,
    input logic        irq_o,
    input logic        soft_clr,
    input logic [15:0] sts_rd,
    input logic [15:0] ien_rd
);
    assert_halted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[4:1] == 4'd1) |-> (bus_rdata[5] == !run_o));

    assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i[0] && bus_wr && bus_addr[4:1] == 4'd1 && bus_wdata[0] && !soft_clr)
        |=> sts_rd[0]);

    assert_irq_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i[2] && ien_rd[2] && !soft_clr && !(bus_wr && bus_addr[4:1] == 4'd2))
        |=> irq_o);

    assert_base_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[4:1] == 4'd4) |-> (bus_rdata[11:0] == 12'h000));

    assert_port_bit7_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[4:1] == 4'd8 || bus_addr[4:1] == 4'd9) |-> bus_rdata[7]);

    assert_soft_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (!run_o && sof_o == 8'h40 && !irq_o));
endmodule

bind usbhc_regs usbhc_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ev_i      (ev_i),
    .run_o     (run_o),
    .sof_o     (sof_o),
    .irq_o     (irq_o),
    .soft_clr  (soft_clr),
    .sts_rd    (sts_rd),
    .ien_rd    (ien_rd)
);

// File: tb/usbhc_regs_bench.sv
`timescale 1ns/1ps
module usbhc_regs_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0;
    logic [4:0]  bus_addr = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic [4:0]  ev_i = 0;
    logic        frame_tick = 0;
    logic [1:0]  port_conn = 0, port_en = 0, port_ls = 0;
    logic        run_o, max64_o, hc_rst_o, irq_o;
    logic [1:0]  port_rst_o;
    logic [31:0] flbase_o;
    logic [10:0] frnum_o;
    logic [7:0]  sof_o;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    usbhc_regs u_usbhc_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_i(ev_i),
        .frame_tick(frame_tick), .port_conn(port_conn), .port_en(port_en),
        .port_ls(port_ls), .run_o(run_o), .max64_o(max64_o),
        .hc_rst_o(hc_rst_o), .port_rst_o(port_rst_o), .flbase_o(flbase_o),
        .frnum_o(frnum_o), .sof_o(sof_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Model of the sticky update: clear mask first, events OR in afterwards.
    function automatic logic [4:0] sts_next(input logic [4:0] s, input logic [4:0] ev, input logic [4:0] clr);
        return (s & ~clr) | ev;
    endfunction

    function automatic logic [15:0] port_word(input logic prst, input logic ls, input logic ec,
                                              input logic en, input logic cc, input logic cn);
        return {6'b0, prst, ls, 1'b1, 3'b0, ec, en, cc, cn};
    endfunction

    initial begin
        #(200000 * 8);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [4:0]  s_exp;
        logic [3:0]  ien_exp;
        logic [1:0]  cn_q, cc, en_q, ec;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R13 reset state
        rd(5'h00, d); check("R13 cmd", d, 16'h0000);
        rd(5'h02, d); check("R13 sts", d, 16'h0020);
        rd(5'h04, d); check("R13 ien", d, 16'h0000);
        rd(5'h06, d); check("R13 frnum", d, 16'h0000);
        rd(5'h08, d); check("R13 base lo", d, 16'h0000);
        rd(5'h0A, d); check("R13 base hi", d, 16'h0000);
        rd(5'h0C, d); check("R13 sof", d, 16'h0040);
        rd(5'h10, d); check("R13 port0", d, 16'h0080);
        rd(5'h12, d); check("R13 port1", d, 16'h0080);
        check("R13 irq", irq_o, 0);

        // R1 unmapped offsets and ignored address bit 0
        rd(5'h0E, d); check("R1 unmapped 0E", d, 16'h0000);
        rd(5'h1E, d); check("R1 unmapped 1E", d, 16'h0000);
        rd(5'h0D, d); check("R1 odd addr", d, 16'h0040);

        // R2 command outputs and reserved bits
        wr(5'h00, 16'hFF81);
        check("R2 run_o", run_o, 1); check("R2 max64_o", max64_o, 1);
        rd(5'h00, d); check("R2 cmd read", d, 16'h0081);
        // R3 halted clears while running
        rd(5'h02, d); check("R3 halted low", d[5], 0);
        wr(5'h00, 16'h007D);
        rd(5'h00, d); check("R2 cmd read 2", d, 16'h0001);
        check("R2 max64_o off", max64_o, 0);
        wr(5'h00, 16'h0000);
        rd(5'h02, d); check("R3 halted high", d[5], 1);

        // R7 frame list pointer
        wr(5'h08, 16'hFFFF); wr(5'h0A, 16'h1234);
        rd(5'h08, d); check("R7 base lo", d, 16'hF000);
        check("R7 flbase_o", flbase_o, 32'h1234F000);

        // R8 SOF byte
        wr(5'h0C, 16'hABCD);
        rd(5'h0C, d); check("R8 sof read", d, 16'h00CD);
        check("R8 sof_o", sof_o, 8'hCD);

        // R6 frame number write, wrap, tick/write collision
        wr(5'h06, 16'hFFFF);
        rd(5'h06, d); check("R6 frnum mask", d, 16'h07FF);
        @(negedge clk); frame_tick = 1; @(negedge clk); frame_tick = 0;
        check("R6 frnum wrap", frnum_o, 11'h000);
        @(negedge clk); frame_tick = 1; repeat (3) @(negedge clk); frame_tick = 0;
        check("R6 frnum count", frnum_o, 11'h003);
        @(negedge clk); frame_tick = 1; bus_wr = 1; bus_addr = 5'h06; bus_wdata = 16'h0100;
        @(negedge clk); frame_tick = 0; bus_wr = 0;
        check("R6 write wins", frnum_o, 11'h100);

        // R4 directed: event and clear on same bit
        @(negedge clk); ev_i = 5'h01; @(negedge clk); ev_i = 0;
        @(negedge clk); ev_i = 5'h01; bus_wr = 1; bus_addr = 5'h02; bus_wdata = 16'h0001;
        @(negedge clk); ev_i = 0; bus_wr = 0;
        rd(5'h02, d); check("R4 event wins", d, 16'h0021);
        wr(5'h02, 16'h0000);
        rd(5'h02, d); check("R4 zero write", d, 16'h0021);
        wr(5'h02, 16'h001F);
        rd(5'h02, d); check("R4 cleared", d, 16'h0020);

        // R4/R5 random events against random clears and enables
        s_exp = 0;
        ien_exp = 4'($urandom);
        wr(5'h04, {12'hFFF, ien_exp});
        rd(5'h04, d); check("R5 ien read", d, {12'h000, ien_exp});
        bus_addr = 5'h02;
        for (int i = 0; i < 400; i++) begin
            logic [4:0] ev, cm;
            logic       w;
            ev = (($urandom % 4) == 0) ? 5'($urandom) : 5'h00;
            w  = ($urandom % 2) == 1;
            cm = 5'($urandom);
            @(negedge clk);
            ev_i = ev; bus_wr = w; bus_wdata = {11'h000, cm};
            @(negedge clk);
            ev_i = 0; bus_wr = 0;
            s_exp = sts_next(s_exp, ev, w ? cm : 5'h00);
            #1;
            check("R4 random sts", bus_rdata, {10'h000, 1'b1, s_exp});
            check("R5 random irq", irq_o, |(s_exp[3:0] & ien_exp));
        end
        wr(5'h02, 16'h001F);
        @(negedge clk); ev_i = 5'h10; @(negedge clk); ev_i = 0;
        wr(5'h04, 16'h000F);
        check("R5 perr no irq", irq_o, 0);
        wr(5'h02, 16'h0010);

        // R9/R10 random port activity
        cn_q = 0; cc = 0; en_q = 0; ec = 0;
        for (int i = 0; i < 300; i++) begin
            logic [1:0] nc, ne;
            logic       w;
            logic       p;
            logic [15:0] wd;
            nc = 2'($urandom); ne = 2'($urandom);
            w  = ($urandom % 3) == 0; p = 1'($urandom);
            wd = {6'h00, 1'b0, 5'h00, 1'($urandom), 1'b0, 1'($urandom), 1'b0};
            @(negedge clk);
            port_conn = nc; port_en = ne;
            bus_wr = w; bus_addr = p ? 5'h12 : 5'h10; bus_wdata = wd;
            @(negedge clk);
            bus_wr = 0;
            for (int k = 0; k < 2; k++) begin
                logic clc, cle;
                clc = w && (p == k) && wd[1];
                cle = w && (p == k) && wd[3];
                cc[k] = (nc[k] ^ cn_q[k]) | (cc[k] & ~clc);
                ec[k] = (ne[k] ^ en_q[k]) | (ec[k] & ~cle);
            end
            cn_q = nc; en_q = ne;
            rd(5'h10, d); check("R9 R10 port0", d, port_word(0, 0, ec[0], en_q[0], cc[0], cn_q[0]));
            rd(5'h12, d); check("R9 R10 port1", d, port_word(0, 0, ec[1], en_q[1], cc[1], cn_q[1]));
            // reading takes clocks; inputs held so no further changes occur
        end

        // R11 low speed, port reset bit, reserved bits
        @(negedge clk); port_ls = 2'b10;
        wr(5'h12, 16'hFDFF & 16'h0200 | 16'h0200);
        rd(5'h12, d); check("R11 port1 ls and reset", d[9:7], 3'b111);
        check("R11 port_rst_o", port_rst_o, 2'b10);
        check("R11 reserved zero", {d[15:10], d[6:4]}, 0);

        // R12 soft reset
        wr(5'h00, 16'h0081); wr(5'h06, 16'h0055); wr(5'h04, 16'h000F);
        @(negedge clk); ev_i = 5'h04; @(negedge clk); ev_i = 0;
        check("R12 irq before", irq_o, 1);
        @(negedge clk); bus_wr = 1; bus_addr = 5'h00; bus_wdata = 16'h0083;
        @(negedge clk); bus_wr = 0;
        check("R12 hc_rst_o pulse", hc_rst_o, 1);
        check("R12 run cleared", run_o, 0);
        check("R12 irq cleared", irq_o, 0);
        check("R12 frnum cleared", frnum_o, 0);
        check("R12 sof restored", sof_o, 8'h40);
        check("R12 port reset cleared", port_rst_o, 2'b00);
        rd(5'h00, d); check("R12 cmd read", d, 16'h0000);
        check("R12 pulse ends", hc_rst_o, 0);
        rd(5'h04, d); check("R12 ien cleared", d, 16'h0000);
        rd(5'h0A, d); check("R12 base cleared", d, 16'h0000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule